// File: doc/BRIEF.md
# Self-Refresh Entry/Exit Sequencer

This block sits between a memory controller and a DDR3-class SDRAM. It moves the device into self refresh and back out again. When the controller requests entry and reports that no burst is still running, the sequencer takes over the command bus. It closes all banks with a precharge-all command, waits out the precharge time, and then issues REFRESH in the same cycle that it drops CKE. It keeps the clock stable for a programmable settling window. After that it tells the clock generator that the clock may be stopped.

An exit request can arrive at any point during self refresh. The block holds it until the minimum CKE-low residency has elapsed. It then withdraws clock-stop permission and waits for the clock to settle. Next it raises CKE and drives only NOP until the exit delay has passed. It then issues a ZQ long calibration. The block reports readiness in two steps. The first flag says that commands not needing a locked DLL are legal. The second flag says that DLL-dependent commands are legal, and it is raised only once both the DLL lock window and the calibration have finished. Every interval is a cycle count taken from a configuration input.

Top module: `srefSeq`

## Requirements
- R1: Out of reset the block drives cke=1, cmd=NOP, odtEn=1, readyNoDll=1, readyDll=1 and clkStopOk=0. The cmd encoding is 0=NOP, 1=precharge-all, 2=REFRESH, 3=ZQ long calibration.
- R2: An entry request is refused while banksIdle is low, and cmd stays NOP with cke high. If enterReq and banksIdle are both high in a cycle, precharge-all appears in the next cycle.
- R3: REFRESH is issued with cke low and odtEn low, exactly max(cfgTrp,1)+1 cycles after the precharge-all cycle.
- R4: The cycle after REFRESH carries NOP. While cke is low, no command other than that one REFRESH is issued.
- R5: clkStopOk rises max(cfgTcksre,1)+1 cycles after the REFRESH cycle, and it is never high while cke is high.
- R6: An exit request seen in cycle REF+d is pending until the residency count is over. The last clkStopOk cycle is max(first clkStopOk cycle, REF+cfgTckesr, REF+d).
- R7: cke rises max(cfgTcksrx,1)+1 cycles after the last clkStopOk cycle.
- R8: From the cke rise until ZQ calibration, only NOP is issued. ZQ calibration comes max(cfgTxs,1) cycles after the first cke-high cycle, and readyNoDll rises in the cycle that follows it.
- R9: readyDll and odtEn return high in cycle max(ZQ+1+max(cfgTzq,1), CKEHI+cfgTxsdll+1), where ZQ is the calibration cycle and CKEHI is the first cke-high cycle. readyDll never rises without readyNoDll.
- R10: An exit request outside self refresh has no effect. cke, cmd and readyDll stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enterReq | input | 1 | Request to enter self refresh |
| exitReq | input | 1 | Request to leave self refresh |
| banksIdle | input | 1 | Controller reports no burst in progress |
| cfgTrp | input | CNT_W | Precharge wait, cycles |
| cfgTcksre | input | CNT_W | Clock-stable window after entry |
| cfgTckesr | input | CNT_W | Minimum CKE-low residency |
| cfgTcksrx | input | CNT_W | Clock-stable window before exit |
| cfgTxs | input | CNT_W | Exit delay for non-DLL commands |
| cfgTxsdll | input | CNT_W | Exit delay for DLL-dependent commands |
| cfgTzq | input | CNT_W | ZQ long calibration duration |
| cke | output | 1 | Clock enable to the device |
| cmd | output | 2 | Command code (see R1) |
| odtEn | output | 1 | On-die termination permitted |
| clkStopOk | output | 1 | Clock may be stopped |
| readyNoDll | output | 1 | Non-DLL commands legal |
| readyDll | output | 1 | DLL-dependent commands legal |

## Verification
The hardest case to reach is an exit request that arrives while the residency count is still running, either during the entry cycle itself or before the clock-stable window closes. In that case the pending latch, and not the live request, releases the sequence. The stimulus reaches it by sweeping the request offset against several residency and settling counts. This covers offsets both before and after each count expires, so the last clock-stop cycle is set in turn by each of the three terms of R6. The exit side is swept in the same way, with exit delays both shorter and longer than calibration plus its lead-in, so that each term of R9 governs.

// File: rtl/srefPkg.sv
package srefPkg;
  typedef enum logic [1:0] {CMD_NOP = 2'd0, CMD_PREA = 2'd1, CMD_REF = 2'd2, CMD_ZQCL = 2'd3} cmdT;
  typedef enum logic [2:0] {W_TRP, W_CKSRE, W_CKSRX, W_XS, W_ZQ} waitSelT;
  typedef enum logic [3:0] {S_IDLE, S_PRE, S_TRP, S_SRE, S_CKSRE, S_SR,
                            S_CKSRX, S_XS, S_ZQ, S_ZQW} stateT;
  typedef struct packed {
    logic     loadWait;
    waitSelT  waitSel;
    logic     loadRes;
    logic     resIsDll;
  } strobeT;
endpackage

// File: rtl/srefTimer.sv
module srefTimer import srefPkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  logic [CNT_W-1:0] cfgTrp,
  input  logic [CNT_W-1:0] cfgTcksre,
  input  logic [CNT_W-1:0] cfgTckesr,
  input  logic [CNT_W-1:0] cfgTcksrx,
  input  logic [CNT_W-1:0] cfgTxs,
  input  logic [CNT_W-1:0] cfgTxsdll,
  input  logic [CNT_W-1:0] cfgTzq,
  output logic             waitDone,
  output logic             resDone
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] waitCnt, resCnt, waitVal, resVal;

  always_comb begin
    case (strobe.waitSel)
      W_TRP:   waitVal = cfgTrp;
      W_CKSRE: waitVal = cfgTcksre;
      W_CKSRX: waitVal = cfgTcksrx;
      W_XS:    waitVal = cfgTxs;
      W_ZQ:    waitVal = cfgTzq;
      default: waitVal = '0;
    endcase
    resVal = strobe.resIsDll ? cfgTxsdll : cfgTckesr;
  end

  // Phase counter: a wait state lasts max(N,1) cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitCnt <= '0;
    else if (strobe.loadWait) waitCnt <= waitVal;
    else if (waitCnt != '0) waitCnt <= waitCnt - ONE;
  end

  // Residency / DLL-lock counter runs alongside the phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resCnt <= '0;
    else if (strobe.loadRes) resCnt <= resVal;
    else if (resCnt != '0) resCnt <= resCnt - ONE;
  end

  assign waitDone = (waitCnt <= ONE);
  assign resDone  = (resCnt == '0);
endmodule

// File: rtl/srefCtrl.sv
module srefCtrl import srefPkg::*; (
  input  logic   clk,
  input  logic   rstN,
  input  logic   enterReq,
  input  logic   exitReq,
  input  logic   banksIdle,
  input  logic   waitDone,
  input  logic   resDone,
  output strobeT strobe,
  output logic   cke,
  output cmdT    cmd,
  output logic   odtEn,
  output logic   clkStopOk,
  output logic   readyNoDll,
  output logic   readyDll
);
  stateT state, nextState;
  logic  exitPending, inSref;

  assign inSref = (state == S_SRE) || (state == S_CKSRE) || (state == S_SR);

  always_comb begin
    nextState = state;
    strobe    = '{loadWait: 1'b0, waitSel: W_TRP, loadRes: 1'b0, resIsDll: 1'b0};
    case (state)
      S_IDLE:  if (enterReq && banksIdle) nextState = S_PRE;
      S_PRE: begin
        nextState = S_TRP;
        strobe.loadWait = 1'b1; strobe.waitSel = W_TRP;
      end
      S_TRP: if (waitDone) begin
        nextState = S_SRE;
        strobe.loadRes = 1'b1;
      end
      S_SRE: begin
        nextState = S_CKSRE;
        strobe.loadWait = 1'b1; strobe.waitSel = W_CKSRE;
      end
      S_CKSRE: if (waitDone) nextState = S_SR;
      S_SR: if ((exitPending || exitReq) && resDone) begin
        nextState = S_CKSRX;
        strobe.loadWait = 1'b1; strobe.waitSel = W_CKSRX;
      end
      S_CKSRX: if (waitDone) begin
        nextState = S_XS;
        strobe.loadWait = 1'b1; strobe.waitSel = W_XS;
        strobe.loadRes  = 1'b1; strobe.resIsDll = 1'b1;
      end
      S_XS: if (waitDone) nextState = S_ZQ;
      S_ZQ: begin
        nextState = S_ZQW;
        strobe.loadWait = 1'b1; strobe.waitSel = W_ZQ;
      end
      S_ZQW: if (waitDone && resDone) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      exitPending <= 1'b0;
    end else begin
      state       <= nextState;
      exitPending <= inSref && (exitPending || exitReq);
    end
  end

  always_comb begin
    cmd = CMD_NOP;
    if (state == S_PRE) cmd = CMD_PREA;
    if (state == S_SRE) cmd = CMD_REF;
    if (state == S_ZQ)  cmd = CMD_ZQCL;
  end

  assign cke        = !(inSref || (state == S_CKSRX));
  assign odtEn      = (state == S_IDLE);
  assign clkStopOk  = (state == S_SR);
  assign readyNoDll = (state == S_IDLE) || (state == S_ZQW);
  assign readyDll   = (state == S_IDLE);
endmodule

// File: rtl/srefSeq.sv
module srefSeq import srefPkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enterReq,
  input  logic             exitReq,
  input  logic             banksIdle,
  input  logic [CNT_W-1:0] cfgTrp,
  input  logic [CNT_W-1:0] cfgTcksre,
  input  logic [CNT_W-1:0] cfgTckesr,
  input  logic [CNT_W-1:0] cfgTcksrx,
  input  logic [CNT_W-1:0] cfgTxs,
  input  logic [CNT_W-1:0] cfgTxsdll,
  input  logic [CNT_W-1:0] cfgTzq,
  output logic             cke,
  output logic [1:0]       cmd,
  output logic             odtEn,
  output logic             clkStopOk,
  output logic             readyNoDll,
  output logic             readyDll
);
  strobeT strobe;
  logic   waitDone, resDone;
  cmdT    cmdInt;

  srefTimer #(.CNT_W(CNT_W)) uTimer (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgTrp(cfgTrp), .cfgTcksre(cfgTcksre), .cfgTckesr(cfgTckesr),
    .cfgTcksrx(cfgTcksrx), .cfgTxs(cfgTxs), .cfgTxsdll(cfgTxsdll),
    .cfgTzq(cfgTzq), .waitDone(waitDone), .resDone(resDone)
  );

  srefCtrl uCtrl (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .exitReq(exitReq),
    .banksIdle(banksIdle), .waitDone(waitDone), .resDone(resDone),
    .strobe(strobe), .cke(cke), .cmd(cmdInt), .odtEn(odtEn),
    .clkStopOk(clkStopOk), .readyNoDll(readyNoDll), .readyDll(readyDll)
  );

  assign cmd = cmdInt;
endmodule

// File: rtl/srefChk.sv
module srefChk (
  input logic       clk,
  input logic       rstN,
  input logic       banksIdle,
  input logic       cke,
  input logic [1:0] cmd,
  input logic       odtEn,
  input logic       clkStopOk,
  input logic       readyNoDll,
  input logic       readyDll
);
  AST_PREA_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 2'd1) |-> $past(banksIdle)); // R2
  AST_REF_CKE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 2'd2) |-> !cke); // R3
  AST_REF_ODT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 2'd2) |-> !odtEn); // R3
  AST_NOP_AFTER_REF: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 2'd2) |=> (cmd == 2'd0)); // R4
  AST_STOP_CKE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    clkStopOk |-> !cke); // R5
  AST_CKE_RISE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (cmd == 2'd0) && !readyNoDll); // R8
  AST_DLL_IMPLIES_NODLL: assert property (@(posedge clk) disable iff (!rstN)
    readyDll |-> readyNoDll); // R9
endmodule

bind srefSeq srefChk uChk (
  .clk(clk), .rstN(rstN), .banksIdle(banksIdle), .cke(cke), .cmd(cmd),
  .odtEn(odtEn), .clkStopOk(clkStopOk), .readyNoDll(readyNoDll),
  .readyDll(readyDll)
);

// File: tb/tb_srefSeq.sv
module tb_srefSeq;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic enterReq = 1'b0, exitReq = 1'b0, banksIdle = 1'b0;
  logic [CNT_W-1:0] cfgTrp = '0, cfgTcksre = '0, cfgTckesr = '0, cfgTcksrx = '0;
  logic [CNT_W-1:0] cfgTxs = '0, cfgTxsdll = '0, cfgTzq = '0;
  logic cke, odtEn, clkStopOk, readyNoDll, readyDll;
  logic [1:0] cmd;

  int cyc = 0, nTests = 0, nFail = 0;
  int mPrea, mRef, mStop, mStopCnt, mCke, mZq, mNoDll, mDll, mBad;
  logic mOdtRef;
  logic armed = 1'b0;

  srefSeq #(.CNT_W(CNT_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (armed) begin
    if (!cke && cmd != 2'd0 && cmd != 2'd2) mBad++;          // R4
    if (cke && clkStopOk) mBad++;                             // R5
    if (mCke >= 0 && mZq < 0 && cmd != 2'd0 && cmd != 2'd3) mBad++; // R8
    if (mPrea >= 0 && mZq < 0 && readyNoDll) mBad++;          // R8
    if (cmd == 2'd1 && mPrea < 0) mPrea = cyc;
    if (cmd == 2'd2 && mRef < 0) begin mRef = cyc; mOdtRef = odtEn; end
    if (clkStopOk) begin if (mStop < 0) mStop = cyc; mStopCnt++; end
    if (mRef >= 0 && cke && mCke < 0) mCke = cyc;
    if (cmd == 2'd3 && mZq < 0) mZq = cyc;
    if (mZq >= 0 && readyNoDll && mNoDll < 0) mNoDll = cyc;
    if (mZq >= 0 && readyDll && mDll < 0) mDll = cyc;
  end

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runSeq(input int trp, input int tsre, input int tesr, input int tsrx,
                        input int txs, input int tdll, input int tzq, input int d,
                        input int busy);
    int e, pE, rE, s0, cE, xE, zE, dE;
    @(negedge clk);
    cfgTrp = CNT_W'(trp); cfgTcksre = CNT_W'(tsre); cfgTckesr = CNT_W'(tesr);
    cfgTcksrx = CNT_W'(tsrx); cfgTxs = CNT_W'(txs); cfgTxsdll = CNT_W'(tdll);
    cfgTzq = CNT_W'(tzq);
    mPrea = -1; mRef = -1; mStop = -1; mStopCnt = 0; mCke = -1; mZq = -1;
    mNoDll = -1; mDll = -1; mBad = 0; mOdtRef = 1'b1; armed = 1'b1;
    enterReq = 1'b1; banksIdle = 1'b0;
    for (int i = 0; i < busy; i++) begin
      @(negedge clk);
      check("R2 refused while busy", {30'd0, cke, cmd == 2'd0}, 3);
    end
    banksIdle = 1'b1; e = cyc;
    @(negedge clk);
    enterReq = 1'b0; banksIdle = 1'b0;
    pE = e + 1;
    rE = pE + 1 + mx(trp, 1);
    s0 = rE + 1 + mx(tsre, 1);
    while (cyc < rE + d) @(negedge clk);
    exitReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0;
    cE = mx(s0, mx(rE + tesr, rE + d));
    xE = cE + 1 + mx(tsrx, 1);
    zE = xE + mx(txs, 1);
    dE = mx(zE + 1 + mx(tzq, 1), xE + tdll + 1);
    for (int i = 0; i < 300 && mDll < 0; i++) @(negedge clk);
    check("R2 precharge cycle", mPrea, pE);
    check("R3 refresh cycle", mRef, rE);
    check("R3 odt off at refresh", {31'd0, mOdtRef}, 0);
    check("R5 first clock-stop cycle", mStop, s0);
    check("R6 clock-stop length", mStopCnt, cE - s0 + 1);
    check("R7 cke rise cycle", mCke, xE);
    check("R8 zq cycle", mZq, zE);
    check("R8 readyNoDll cycle", mNoDll, zE + 1);
    check("R9 readyDll cycle", mDll, dE);
    check("R9 odt back", {31'd0, odtEn}, 1);
    check("R4 R5 R8 protocol violations", mBad, 0);
    armed = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cke", {31'd0, cke}, 1);
    check("R1 reset cmd", {30'd0, cmd}, 0);
    check("R1 reset odt/ready", {29'd0, odtEn, readyNoDll, readyDll}, 7);
    check("R1 reset clkStopOk", {31'd0, clkStopOk}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R10: exit request while not in self refresh
    exitReq = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R10 exit ignored", {28'd0, cke, cmd, readyDll}, 9);
    end
    exitReq = 1'b0;
    runSeq(1, 1, 2, 1, 2, 4, 1, 0, 3);
    foreach (cfgTrp[i]) begin end
    for (int trp = 0; trp < 3; trp++)
      for (int tsre = 0; tsre < 3; tsre++)
        for (int ei = 0; ei < 3; ei++)
          for (int tsrx = 0; tsrx < 3; tsrx += 2)
            for (int xi = 0; xi < 3; xi++)
              for (int zi = 0; zi < 2; zi++)
                for (int di = 0; di < 4; di++) begin
                  int tesr = (ei == 0) ? 1 : (ei == 1) ? 3 : 6;
                  int txs  = (xi == 0) ? 2 : (xi == 1) ? 6 : 0;
                  int tdll = (xi == 0) ? 5 : (xi == 1) ? 3 : 0;
                  int tzq  = (zi == 0) ? 1 : 4;
                  int d    = (di == 0) ? 0 : (di == 1) ? 2 : (di == 2) ? 5 : 9;
                  runSeq(trp, tsre, tesr, tsrx, txs, tdll, tzq, d, di);
                end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule